// File: doc/BRIEF.md
# Flow-Through Byte-Lane Synchronous SRAM Core

This block is the storage core of a synchronous static memory. The word is 36 bits wide, held as four 9-bit lanes. The core is selected by three chip-enable inputs of mixed polarity. A write is committed on the rising clock edge through one write strobe per lane. The lane strobes come from a global-write input that forces every lane, or from per-lane inputs that count only while a separate byte-write strobe is low.

A read is flow-through. The address is captured at the edge, and the array word at that address is presented combinationally during the following cycle, with no output register. The output driver is gated at once by an asynchronous output enable and a sleep input. High impedance is modelled by a drive-enable output: when it is low, the data output reads zero. The sleep input blocks writes, and the array keeps its contents while it is high.

The depth is a parameter. Burst address generation is handled by a separate sequencer, which supplies the address on `addr_i`.

Top module: `fts_sram_core`

## Requirements
- R1: Lane k (k = 0..3) occupies `wdata_i`/`dq_o` bits [9k+8:9k], and `lane_wr_n_i[k]` selects that lane.
- R2: On a selected, awake edge with `gwr_n_i` high and `bwr_n_i` low, exactly the lanes whose `lane_wr_n_i` bit is 0 take `wdata_i`. The other lanes keep their previous contents.
- R3: With `gwr_n_i` and `bwr_n_i` both high, `lane_wr_n_i` is ignored. No lane is written, and the cycle is a read.
- R4: On a selected, awake edge, `gwr_n_i` low writes all four lanes, whatever `bwr_n_i` and `lane_wr_n_i` are.
- R5: The core is selected only when `en_n_i` is 0, `en_hi_i` is 1 and `en2_n_i` is 0 at the edge. An unselected edge writes nothing, and `dq_drv_o` is low for the following cycle.
- R6: After a selected read edge, `dq_o` shows the array word at the captured address during the following cycle, and `dq_drv_o` is high, provided `oe_n_i` and `sleep_i` are low.
- R7: `dq_drv_o` is low whenever `oe_n_i` is high, the change taking effect without waiting for a clock edge. It is also low in the cycle after a write edge.
- R8: While `sleep_i` is high, no write takes place and `dq_drv_o` is low. Contents written before the sleep are read back unchanged afterwards.
- R9: After a clock edge with `rst_n` low, `dq_drv_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the control state |
| addr_i | input | AW | Word address from the burst sequencer |
| wdata_i | input | 36 | Write data, four 9-bit lanes |
| en_n_i | input | 1 | Primary chip enable, active low |
| en_hi_i | input | 1 | Secondary chip enable, active high |
| en2_n_i | input | 1 | Secondary chip enable, active low |
| gwr_n_i | input | 1 | Global write, active low, writes all lanes |
| bwr_n_i | input | 1 | Byte-write strobe, active low, qualifies lane_wr_n_i |
| lane_wr_n_i | input | 4 | Per-lane write selects, active low |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Power-down, active high |
| dq_o | output | 36 | Read data, zero while not driven |
| dq_drv_o | output | 1 | Output driver enable; low models high impedance |

## Verification
The assertions check on every cycle that the output driver stays off in these cases:
- after an unselected edge;
- after a global write;
- after any reset edge;
- while the output enable is high;
- while sleep is high.

Only the bench's scenarios can show that lane masking preserves the unwritten lanes and that the byte strobe gates the lane inputs. The same holds for sleep-time writes being dropped and for the flow-through word matching what was stored. To show these, a behavioural model of the array is compared with the output on every clock.

// File: rtl/fts_sram_core.sv
module fts_sram_core #(
  parameter int DEPTH  = 64,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int AW = $clog2(DEPTH),
  localparam int W  = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             en_n_i,
  input  logic             en_hi_i,
  input  logic             en2_n_i,
  input  logic             gwr_n_i,
  input  logic             bwr_n_i,
  input  logic [LANES-1:0] lane_wr_n_i,
  input  logic             oe_n_i,
  input  logic             sleep_i,
  output logic [W-1:0]     dq_o,
  output logic             dq_drv_o
);

  logic [W-1:0]     mem [DEPTH];
  logic [LANES-1:0] lane_we;
  logic [AW-1:0]    addr_q;
  logic             sel_q, wr_q;

  wire chip_sel = !en_n_i && en_hi_i && !en2_n_i;
  wire active   = chip_sel && !sleep_i;

  always_comb begin
    if (!active)       lane_we = '0;
    else if (!gwr_n_i) lane_we = '1;
    else if (!bwr_n_i) lane_we = ~lane_wr_n_i;
    else               lane_we = '0;
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++)
      if (lane_we[k]) mem[addr_i][k*LANE_W +: LANE_W] <= wdata_i[k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q <= active;
      wr_q  <= |lane_we;
      if (active) addr_q <= addr_i;
    end
  end

  assign dq_drv_o = sel_q && !wr_q && !oe_n_i && !sleep_i;
  assign dq_o     = dq_drv_o ? mem[addr_q] : '0;

endmodule

module fts_sram_core_chk (
  input logic clk,
  input logic rst_n,
  input logic en_n_i,
  input logic en_hi_i,
  input logic en2_n_i,
  input logic gwr_n_i,
  input logic oe_n_i,
  input logic sleep_i,
  input logic dq_drv_o
);
  // R5
  unsel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!en_n_i && en_hi_i && !en2_n_i) |=> !dq_drv_o);
  // R7
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> !dq_drv_o);
  // R7
  write_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n_i && en_hi_i && !en2_n_i && !sleep_i && !gwr_n_i) |=> !dq_drv_o);
  // R8
  sleep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |-> !dq_drv_o);
  // R9
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> !dq_drv_o);
endmodule

bind fts_sram_core fts_sram_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_n_i(en_n_i), .en_hi_i(en_hi_i),
  .en2_n_i(en2_n_i), .gwr_n_i(gwr_n_i), .oe_n_i(oe_n_i),
  .sleep_i(sleep_i), .dq_drv_o(dq_drv_o)
);

// File: tb/fts_sram_core_test.sv
`timescale 1ns/1ps
module fts_sram_core_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  addr_i = '0;
  logic [35:0] wdata_i = '0;
  logic        en_n_i = 1, en_hi_i = 0, en2_n_i = 1;
  logic        gwr_n_i = 1, bwr_n_i = 1;
  logic [3:0]  lane_wr_n_i = 4'hF;
  logic        oe_n_i = 0, sleep_i = 0;
  logic [35:0] dq_o;
  logic        dq_drv_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [35:0] mdl [64];
  bit          m_sel = 0, m_wr = 0;
  int          m_addr = 0;

  fts_sram_core uut (.*);

  always #2 clk = ~clk;

  task automatic compare(string tag);
    bit exp_drv;
    exp_drv = m_sel && !m_wr && !oe_n_i && !sleep_i;
    n_chk++;
    if (dq_drv_o !== exp_drv) begin
      n_fail++;
      $display("FAIL %s drive actual=%0b expected=%0b", tag, dq_drv_o, exp_drv);
    end
    if (exp_drv) begin
      n_chk++;
      if (dq_o !== mdl[m_addr]) begin
        n_fail++;
        $display("FAIL %s data actual=%h expected=%h", tag, dq_o, mdl[m_addr]);
      end
    end
  endtask

  task automatic step(string tag, int a, logic [35:0] d, logic [2:0] en,
                      logic gw, logic bw, logic [3:0] lw, logic oe, logic sl);
    bit sel, any;
    addr_i = a[5:0]; wdata_i = d;
    {en_n_i, en_hi_i, en2_n_i} = en;
    gwr_n_i = gw; bwr_n_i = bw; lane_wr_n_i = lw; oe_n_i = oe; sleep_i = sl;
    @(posedge clk);
    sel = !en[2] && en[1] && !en[0] && !sl;
    any = 0;
    if (sel)
      for (int k = 0; k < 4; k++)
        if (!gw || (!bw && !lw[k])) begin
          mdl[a][k*9 +: 9] = d[k*9 +: 9];
          any = 1;
        end
    m_sel = sel; m_wr = any;
    if (sel) m_addr = a;
    @(negedge clk);
    compare(tag);
  endtask

  localparam logic [2:0] ON = 3'b010;

  task automatic rd(string tag, int a);
    step(tag, a, 36'h0, ON, 1, 1, 4'hF, 0, 0);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (dq_drv_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R9 drive actual=%0b expected=0", dq_drv_o);
    end
    rst_n = 1;
    for (int i = 0; i < 8; i++)
      step("R4", i, {4{9'h100 + 9'(i)}}, ON, 0, 1, 4'hF, 0, 0);
    for (int i = 0; i < 8; i++) rd("R6", i);
    step("R2", 1, 36'h0_0000_01AB, ON, 1, 0, 4'b1110, 0, 0);
    step("R2", 2, 36'hA_BC00_DE00, ON, 1, 0, 4'b0101, 0, 0);
    step("R2", 3, 36'h0_0155_0000, ON, 1, 0, 4'b1011, 0, 0);
    step("R3", 4, 36'hF_FFFF_FFFF, ON, 1, 1, 4'b0000, 0, 0);
    step("R4", 5, 36'h1_2345_6789, ON, 0, 1, 4'hF, 0, 0);
    step("R4", 6, 36'h9_8765_4321, ON, 0, 0, 4'b1111, 0, 0);
    step("R5", 7, 36'hD_EAD0_0001, 3'b110, 0, 1, 4'hF, 0, 0);
    step("R5", 7, 36'hD_EAD0_0002, 3'b000, 0, 1, 4'hF, 0, 0);
    step("R5", 7, 36'hD_EAD0_0003, 3'b011, 0, 1, 4'hF, 0, 0);
    step("R8", 7, 36'hD_EAD0_0004, ON, 0, 1, 4'hF, 0, 1);
    step("R8", 7, 36'hD_EAD0_0005, ON, 1, 0, 4'b0000, 0, 1);
    rd("R8", 7);
    step("R7", 0, 36'h0, ON, 1, 1, 4'hF, 1, 0);
    rd("R6", 0);
    #0.5 oe_n_i = 1;
    #0.5 compare("R7");
    #0.5 oe_n_i = 0;
    #0.5 compare("R7");
    for (int i = 0; i < 8; i++) rd("R1", i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule